// File: doc/BRIEF.md
# Threshold-Based Interrupt Privilege Selector

This block decides which privilege mode (machine, supervisor or user) takes an interrupt. An arbitration tree elsewhere supplies the control value of the winning interrupt. The block compares that value, as an unsigned number, with two programmable absolute thresholds. The machine threshold is the lowest value that traps to machine mode, and the supervisor threshold is the lowest value that traps to supervisor mode. Because the thresholds are plain magnitudes and not fixed bit fields, each mode can own a different number of levels. Three input flags say which modes are present: user mode, supervisor mode, and user-mode interrupts.

The block also guards the per-interrupt control-byte write path. A write that arrives through the supervisor aperture is dropped if its value would land at or above the machine threshold, and the block flags the rejection. Writes through the machine aperture always pass. Every passed write leaves with its unimplemented low bits forced to 1. The block never rewrites stored control bytes. If the machine threshold is lowered later, the next decision simply uses the new value.

Top module: `irq_mode_sel`

## Requirements
- R1: Only the top CTL_BITS bits of each 8-bit threshold can be written. The remaining low bits always read as 1. With the default CTL_BITS=6, a threshold write of 0x80 gives an effective threshold of 0x83. After reset, both effective thresholds are 0x03.
- R2: If the winning value is greater than or equal to the effective machine threshold, mode_o is 2'b11 (machine).
- R3: Otherwise, if supervisor mode is present and the value is at least the effective supervisor threshold, mode_o is 2'b01 (supervisor).
- R4: Otherwise, mode_o is 2'b00 (user) when user-mode interrupts are present, and 2'b11 (machine) when they are not.
- R5: When user mode is absent, the effective machine threshold is 0, so every interrupt goes to machine mode.
- R6: When the machine threshold is less than or equal to the supervisor threshold, no interrupt is sent to supervisor mode.
- R7: When user-mode interrupts are absent, the effective supervisor threshold is 0, so no interrupt goes to user mode.
- R8: A supervisor-aperture write whose filtered value is at least the effective machine threshold gives ctl_wr_en_o=0 and ctl_wr_reject_o=1 for exactly one cycle per blocked request.
- R9: Machine-aperture writes, and supervisor-aperture writes below the machine threshold, give ctl_wr_en_o=1 with the same index and with the data's low 8-CTL_BITS bits forced to 1.
- R10: The decision is registered. mode_valid_o and mode_o appear one clock after win_valid_i, and mode_valid_o is 0 in every cycle without a request. The write outputs also appear one clock after the request.
- R11: During reset and right after it, mode_valid_o, ctl_wr_en_o and ctl_wr_reject_o are 0. A threshold write is used by the decision and write guard of the following cycle, and stored control bytes are never rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| has_umode_i | input | 1 | User mode is implemented |
| has_smode_i | input | 1 | Supervisor mode is implemented |
| has_uirq_i | input | 1 | User-mode interrupts are implemented |
| thr_wdata_i | input | 8 | Write data for a threshold |
| mthr_we_i | input | 1 | Write the machine threshold |
| sthr_we_i | input | 1 | Write the supervisor threshold |
| win_valid_i | input | 1 | A winning interrupt value is presented |
| win_ctl_i | input | 8 | Control value of the winning interrupt |
| ctl_wr_req_i | input | 1 | Control-byte write request |
| ctl_wr_from_s_i | input | 1 | 1 when the write comes through the supervisor aperture |
| ctl_wr_idx_i | input | IDX_W | Index of the interrupt being written |
| ctl_wr_data_i | input | 8 | Requested control-byte value |
| mode_valid_o | output | 1 | mode_o is valid this cycle |
| mode_o | output | 2 | Selected mode: 11 machine, 01 supervisor, 00 user |
| ctl_wr_en_o | output | 1 | Filtered write strobe |
| ctl_wr_idx_o | output | IDX_W | Index of the filtered write |
| ctl_wr_data_o | output | 8 | Filtered write data |
| ctl_wr_reject_o | output | 1 | A supervisor-aperture write was blocked |

## Verification
The assertions assume that the mode-present flags change only between requests. They also assume the flags are consistent: supervisor mode present implies user mode present, and user-mode interrupts present implies user mode present. They further assume that at most one of the two threshold write enables is active in a cycle. The stimulus changes flags only in idle cycles when nothing is checked, always drives consistent combinations, and writes one threshold per cycle. Winning values include ones without the hardwired low bits, so the compare boundaries are probed from both sides.

// File: rtl/irq_mode_pkg.sv
package irq_mode_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  // Mask of the low bits that are hardwired to 1 when only nbits are kept
  function automatic logic [7:0] low_ones(input int unsigned nbits);
    return 8'hFF >> nbits;
  endfunction
endpackage

// File: rtl/irq_thr_regs.sv
module irq_thr_regs
  import irq_mode_pkg::*;
#(
  parameter int CTL_BITS = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       has_umode_i,
  input  logic       has_uirq_i,
  input  logic [7:0] thr_wdata_i,
  input  logic       mthr_we_i,
  input  logic       sthr_we_i,
  output logic [7:0] m_thr_o,
  output logic [7:0] s_thr_o
);
  localparam logic [7:0] LOW_MASK = low_ones(CTL_BITS);
  localparam int NUM_THR = 2;

  logic [NUM_THR-1:0] we;
  logic [NUM_THR-1:0] present;
  logic [7:0]         eff [NUM_THR];

  assign we      = {sthr_we_i, mthr_we_i};
  assign present = {has_uirq_i, has_umode_i};

  genvar g;
  generate
    for (g = 0; g < NUM_THR; g++) begin : g_thr
      logic [7:0] thr_q;
      always_ff @(posedge clk) begin
        if (rst)
          thr_q <= LOW_MASK;
        else if (we[g])
          thr_q <= thr_wdata_i | LOW_MASK;
      end
      // A threshold whose lower mode is absent collapses to zero
      assign eff[g] = present[g] ? thr_q : 8'h00;
    end
  endgenerate

  assign m_thr_o = eff[0];
  assign s_thr_o = eff[1];

  // R1: while user mode is present the hardwired low bits stay set
  a_r1_low_ones: assert property (@(posedge clk) disable iff (rst)
    has_umode_i |-> ((m_thr_o & LOW_MASK) == LOW_MASK));
endmodule

// File: rtl/irq_mode_decide.sv
module irq_mode_decide
  import irq_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       has_smode_i,
  input  logic       has_uirq_i,
  input  logic [7:0] m_thr_i,
  input  logic [7:0] s_thr_i,
  input  logic       win_valid_i,
  input  logic [7:0] win_ctl_i,
  output logic       mode_valid_o,
  output logic [1:0] mode_o
);
  priv_e pick;

  always_comb begin
    if (win_ctl_i >= m_thr_i)
      pick = PRIV_M;
    else if (has_smode_i && (win_ctl_i >= s_thr_i))
      pick = PRIV_S;
    else if (has_uirq_i)
      pick = PRIV_U;
    else
      pick = PRIV_M;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_valid_o <= 1'b0;
      mode_o       <= PRIV_M;
    end else begin
      mode_valid_o <= win_valid_i;
      if (win_valid_i)
        mode_o <= pick;
    end
  end

  // R2: values at or above the machine threshold land in machine mode
  a_r2_m_route: assert property (@(posedge clk) disable iff (rst)
    (win_valid_i && (win_ctl_i >= m_thr_i)) |=> (mode_valid_o && mode_o == PRIV_M));
  // R6: supervisor mode is only chosen when its band is non-empty
  a_r6_s_band: assert property (@(posedge clk) disable iff (rst)
    (mode_valid_o && mode_o == PRIV_S) |-> ($past(m_thr_i) > $past(s_thr_i)));
  // R4: user mode only when user-mode interrupts exist
  a_r4_u_needs_uirq: assert property (@(posedge clk) disable iff (rst)
    (mode_valid_o && mode_o == PRIV_U) |-> $past(has_uirq_i));
  // R10: the registered valid follows the request by one cycle
  a_r10_valid_lag: assert property (@(posedge clk) disable iff (rst)
    win_valid_i |=> mode_valid_o);
endmodule

// File: rtl/irq_wr_guard.sv
module irq_wr_guard
  import irq_mode_pkg::*;
#(
  parameter int CTL_BITS = 6,
  parameter int IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       m_thr_i,
  input  logic             req_i,
  input  logic             from_s_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic             reject_o
);
  localparam logic [7:0] LOW_MASK = low_ones(CTL_BITS);

  logic [7:0] filt;
  logic       blocked;

  assign filt    = data_i | LOW_MASK;
  assign blocked = from_s_i && (filt >= m_thr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_o   <= 1'b0;
      reject_o  <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= 8'h00;
    end else begin
      wr_en_o  <= req_i && !blocked;
      reject_o <= req_i && blocked;
      if (req_i && !blocked) begin
        wr_idx_o  <= idx_i;
        wr_data_o <= filt;
      end
    end
  end

  // R8: a passed supervisor write always stays below the machine range
  a_r8_s_below_m: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && $past(from_s_i)) |-> (wr_data_o < $past(m_thr_i)));
  // R8: a request is either forwarded or rejected, never both
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(wr_en_o && reject_o));
  // R9: machine-aperture requests are never rejected
  a_r9_m_passes: assert property (@(posedge clk) disable iff (rst)
    (req_i && !from_s_i) |=> (wr_en_o && !reject_o));
endmodule

// File: rtl/irq_mode_sel.sv
module irq_mode_sel
  import irq_mode_pkg::*;
#(
  parameter int CTL_BITS = 6,
  parameter int IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             has_umode_i,
  input  logic             has_smode_i,
  input  logic             has_uirq_i,
  input  logic [7:0]       thr_wdata_i,
  input  logic             mthr_we_i,
  input  logic             sthr_we_i,
  input  logic             win_valid_i,
  input  logic [7:0]       win_ctl_i,
  input  logic             ctl_wr_req_i,
  input  logic             ctl_wr_from_s_i,
  input  logic [IDX_W-1:0] ctl_wr_idx_i,
  input  logic [7:0]       ctl_wr_data_i,
  output logic             mode_valid_o,
  output logic [1:0]       mode_o,
  output logic             ctl_wr_en_o,
  output logic [IDX_W-1:0] ctl_wr_idx_o,
  output logic [7:0]       ctl_wr_data_o,
  output logic             ctl_wr_reject_o
);
  logic [7:0] m_thr;
  logic [7:0] s_thr;

  irq_thr_regs #(.CTL_BITS(CTL_BITS)) u_thr (
    .clk         (clk),
    .rst         (rst),
    .has_umode_i (has_umode_i),
    .has_uirq_i  (has_uirq_i),
    .thr_wdata_i (thr_wdata_i),
    .mthr_we_i   (mthr_we_i),
    .sthr_we_i   (sthr_we_i),
    .m_thr_o     (m_thr),
    .s_thr_o     (s_thr)
  );

  irq_mode_decide u_dec (
    .clk          (clk),
    .rst          (rst),
    .has_smode_i  (has_smode_i),
    .has_uirq_i   (has_uirq_i),
    .m_thr_i      (m_thr),
    .s_thr_i      (s_thr),
    .win_valid_i  (win_valid_i),
    .win_ctl_i    (win_ctl_i),
    .mode_valid_o (mode_valid_o),
    .mode_o       (mode_o)
  );

  irq_wr_guard #(.CTL_BITS(CTL_BITS), .IDX_W(IDX_W)) u_guard (
    .clk       (clk),
    .rst       (rst),
    .m_thr_i   (m_thr),
    .req_i     (ctl_wr_req_i),
    .from_s_i  (ctl_wr_from_s_i),
    .idx_i     (ctl_wr_idx_i),
    .data_i    (ctl_wr_data_i),
    .wr_en_o   (ctl_wr_en_o),
    .wr_idx_o  (ctl_wr_idx_o),
    .wr_data_o (ctl_wr_data_o),
    .reject_o  (ctl_wr_reject_o)
  );

  // R5: without user mode no non-machine mode is ever chosen
  a_r5_m_only: assert property (@(posedge clk) disable iff (rst)
    (win_valid_i && !has_umode_i) |=> (mode_o == PRIV_M));
endmodule

// File: tb/tb_irq_mode_sel.sv
`timescale 1ns/100ps
module tb_irq_mode_sel;
  localparam int CTL_BITS = 6;
  localparam int IDX_W    = 4;
  localparam logic [7:0] MASK = 8'h03;

  typedef struct {
    bit         mv;
    logic [1:0] md;
    bit         we;
    bit         rj;
    logic [3:0] ix;
    logic [7:0] dt;
    int         rn;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hu = 1'b1, hs = 1'b1, hq = 1'b1;
  logic [7:0] thr_wd = 8'h00;
  logic mwe = 1'b0, swe = 1'b0;
  logic wv = 1'b0;
  logic [7:0] wc = 8'h00;
  logic wr = 1'b0, fs = 1'b0;
  logic [IDX_W-1:0] wi = '0;
  logic [7:0] wd = 8'h00;
  logic mode_valid;
  logic [1:0] mode;
  logic wr_en, wr_rej;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0] wr_data;

  int vectors = 0;
  int miscompares = 0;
  exp_t q[$];
  logic [7:0] m_mod = MASK, s_mod = MASK;

  always #2.5 clk = ~clk;

  irq_mode_sel #(.CTL_BITS(CTL_BITS), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst(rst),
    .has_umode_i(hu), .has_smode_i(hs), .has_uirq_i(hq),
    .thr_wdata_i(thr_wd), .mthr_we_i(mwe), .sthr_we_i(swe),
    .win_valid_i(wv), .win_ctl_i(wc),
    .ctl_wr_req_i(wr), .ctl_wr_from_s_i(fs), .ctl_wr_idx_i(wi), .ctl_wr_data_i(wd),
    .mode_valid_o(mode_valid), .mode_o(mode),
    .ctl_wr_en_o(wr_en), .ctl_wr_idx_o(wr_idx), .ctl_wr_data_o(wr_data),
    .ctl_wr_reject_o(wr_rej)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected result
  task automatic cyc(input bit v, input logic [7:0] c, input bit w, input bit s,
                     input logic [3:0] ix, input logic [7:0] d,
                     input bit mw, input bit sw, input logic [7:0] td, input int rn);
    exp_t e;
    logic [7:0] me, se, fd;
    @(negedge clk);
    wv = v; wc = c; wr = w; fs = s; wi = ix; wd = d;
    mwe = mw; swe = sw; thr_wd = td;
    me = hu ? m_mod : 8'h00;
    se = hq ? s_mod : 8'h00;
    e.mv = v;
    if (c >= me) e.md = 2'b11;
    else if (hs && c >= se) e.md = 2'b01;
    else if (hq) e.md = 2'b00;
    else e.md = 2'b11;
    fd = d | MASK;
    e.we = w && !(s && fd >= me);
    e.rj = w && s && (fd >= me);
    e.ix = ix; e.dt = fd; e.rn = rn;
    q.push_back(e);
    if (mw) m_mod = td | MASK;
    if (sw) s_mod = td | MASK;
  endtask

  task automatic idle(input int rn);
    cyc(0, 8'h00, 0, 0, 4'h0, 8'h00, 0, 0, 8'h00, rn);
  endtask

  task automatic set_flags(input bit u, input bit s, input bit ui);
    @(negedge clk);
    wv = 0; wr = 0; mwe = 0; swe = 0;
    hu = u; hs = s; hq = ui;
  endtask

  // Monitor: pops one expected item after each edge and compares
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (!rst && q.size() > 0) begin
        e = q.pop_front();
        vectors++;
        if (mode_valid !== e.mv || (e.mv && mode !== e.md)) begin
          miscompares++;
          $display("FAIL R%0d mode: got valid=%0b mode=%b, expected valid=%0b mode=%b",
                   e.rn, mode_valid, mode, e.mv, e.md);
        end
        if (wr_en !== e.we || wr_rej !== e.rj ||
            (e.we && (wr_idx !== e.ix || wr_data !== e.dt))) begin
          miscompares++;
          $display("FAIL R%0d write: got en=%0b rej=%0b idx=%h data=%h, expected en=%0b rej=%0b idx=%h data=%h",
                   e.rn, wr_en, wr_rej, wr_idx, wr_data, e.we, e.rj, e.ix, e.dt);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    vectors++;  // R11 reset state
    if (mode_valid !== 1'b0 || wr_en !== 1'b0 || wr_rej !== 1'b0) begin
      miscompares++;
      $display("FAIL R11 reset: got valid=%0b en=%0b rej=%0b, expected 0 0 0",
               mode_valid, wr_en, wr_rej);
    end
    @(negedge clk); rst = 1'b0;
    idle(11);                                          // R11 outputs quiet
    cyc(1, 8'h03, 0, 0, 0, 8'h00, 0, 0, 8'h00, 11);    // R11 reset thresholds 0x03
    cyc(1, 8'h02, 0, 0, 0, 8'h00, 0, 0, 8'h00, 4);     // R4 below both -> U
    // R1 program thresholds: machine 0x80 -> 0x83, supervisor 0x40 -> 0x43
    cyc(0, 8'h00, 0, 0, 0, 8'h00, 1, 0, 8'h80, 1);
    cyc(1, 8'h82, 0, 0, 0, 8'h00, 0, 1, 8'h40, 1);     // R1 0x82 below 0x83, old s thr 0x03 -> S
    cyc(1, 8'h83, 0, 0, 0, 8'h00, 0, 0, 8'h00, 2);     // R2 boundary -> M
    cyc(1, 8'hFF, 0, 0, 0, 8'h00, 0, 0, 8'h00, 2);     // R2 top -> M
    cyc(1, 8'h43, 0, 0, 0, 8'h00, 0, 0, 8'h00, 3);     // R3 boundary -> S
    cyc(1, 8'h42, 0, 0, 0, 8'h00, 0, 0, 8'h00, 1);     // R1 s thr low bits set -> U
    cyc(1, 8'h00, 0, 0, 0, 8'h00, 0, 0, 8'h00, 4);     // R4 -> U
    idle(10);                                          // R10 valid drops
    set_flags(1, 0, 1);
    cyc(1, 8'h50, 0, 0, 0, 8'h00, 0, 0, 8'h00, 3);     // R3 no S mode -> U
    set_flags(1, 1, 0);
    cyc(1, 8'h00, 0, 0, 0, 8'h00, 0, 0, 8'h00, 7);     // R7 no U irqs -> S
    cyc(1, 8'h83, 0, 0, 0, 8'h00, 0, 0, 8'h00, 7);     // R7 still M at top
    set_flags(1, 0, 0);
    cyc(1, 8'h10, 0, 0, 0, 8'h00, 0, 0, 8'h00, 4);     // R4 fallback -> M
    set_flags(0, 0, 0);
    cyc(1, 8'h00, 0, 0, 0, 8'h00, 0, 0, 8'h00, 5);     // R5 all -> M
    set_flags(1, 1, 1);
    cyc(0, 8'h00, 0, 0, 0, 8'h00, 0, 1, 8'hC0, 6);     // R6 s thr 0xC3 above m
    cyc(1, 8'h90, 0, 0, 0, 8'h00, 0, 0, 8'h00, 6);     // R6 -> M
    cyc(1, 8'h50, 0, 0, 0, 8'h00, 0, 0, 8'h00, 6);     // R6 -> U
    cyc(0, 8'h00, 0, 0, 0, 8'h00, 0, 1, 8'h80, 6);     // R6 equal thresholds
    cyc(1, 8'h82, 0, 0, 0, 8'h00, 0, 0, 8'h00, 6);     // R6 -> U
    cyc(0, 8'h00, 0, 0, 0, 8'h00, 0, 1, 8'h40, 11);
    // Write guard, machine threshold 0x83
    cyc(0, 8'h00, 1, 1, 4'h5, 8'h83, 0, 0, 8'h00, 8);  // R8 at boundary blocked
    cyc(0, 8'h00, 1, 1, 4'h6, 8'h80, 0, 0, 8'h00, 8);  // R8 low ones push to 0x83
    idle(8);                                           // R8 reject is one cycle
    cyc(0, 8'h00, 1, 1, 4'h7, 8'h7C, 0, 0, 8'h00, 9);  // R9 S write passes as 0x7F
    cyc(0, 8'h00, 1, 0, 4'hA, 8'hFC, 0, 0, 8'h00, 9);  // R9 M write passes as 0xFF
    cyc(1, 8'h83, 1, 0, 4'h3, 8'h10, 0, 0, 8'h00, 10); // R10 both paths same cycle
    // R11 lower machine threshold to 0x43, used on the next cycle
    cyc(1, 8'h7F, 0, 0, 0, 8'h00, 1, 0, 8'h40, 11);    // old thr: 0x7F -> S
    cyc(1, 8'h7F, 0, 0, 0, 8'h00, 0, 0, 8'h00, 11);    // new thr: 0x7F -> M
    cyc(0, 8'h00, 1, 1, 4'h7, 8'h7C, 0, 0, 8'h00, 8);  // R8 now blocked
    cyc(0, 8'h00, 0, 0, 0, 8'h00, 1, 0, 8'h00, 1);     // R1 write 0 -> 0x03
    cyc(0, 8'h00, 1, 1, 4'h2, 8'h00, 0, 0, 8'h00, 8);  // R8 0x03 >= 0x03 blocked
    cyc(1, 8'h02, 0, 0, 0, 8'h00, 0, 0, 8'h00, 3);     // R3 below m, s thr 0x43 -> U
    idle(10);
    idle(10);
    @(posedge clk); #2;
    summary();
    $finish;
  end
endmodule